// File: doc/BRIEF.md
# Two-Entry Receive Message Store

This block sits between a frame receiver and the CPU-facing register logic of a serial bus controller. The receiver presents each complete message as a single payload word with a one-cycle valid strobe. The store keeps up to two such messages. The older one is always presented at the head output. A release command from the CPU discards the head, and any second message moves up at once.

A status flag shows that a message is waiting. A receive interrupt follows that flag, except that it is held low for a programmable number of cycles after every release. Software therefore sees a fresh interrupt edge for a message that moved up.

When a message arrives and both slots are occupied, the message is dropped. A sticky overrun flag records the loss. Only the first loss raises an overrun interrupt pulse. Later losses stay silent until software issues a clear-overrun command.

Top module: `rx_pair_store`

## Requirements
- R1: After reset, the message-available flag, the overrun flag and both interrupts are 0.
- R2: A message that arrives at an empty store, with no hold-off pending, sets the message-available flag at the same clock edge. At that edge the head output takes the arriving payload and the receive interrupt rises.
- R3: Messages leave in arrival order. When two messages are held, a release presents the second message at the head after the same edge, and the message-available flag stays 1.
- R4: Releasing the only held message clears the message-available flag and the receive interrupt at the edge that samples the release.
- R5: Suppose a release that frees a message is sampled at edge k. The receive interrupt is then 0 after edges k through k+HOLDOFF. After edge k+HOLDOFF+1 it equals the message-available flag.
- R6: A message that arrives while both slots are full, with no release in the same cycle, is discarded and sets the overrun flag. Both held messages are kept unchanged.
- R7: The overrun interrupt is a one-cycle pulse at the edge where an overrun occurs while the overrun flag is 0. Overruns that occur while the flag is already 1 raise no pulse.
- R8: The clear-overrun command resets the overrun flag. If an overrun occurs in the same cycle as the clear command, the flag stays 1.
- R9: A release command on an empty store changes no output.
- R10: A message that arrives in the same cycle as a release while both slots are full is accepted as the newer entry and does not set the overrun flag.

Parameters: `DATA_W` sets the payload width. `HOLDOFF` sets the receive-interrupt hold-off after a release and must be at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msgValid | input | 1 | One-cycle strobe for a complete message from the receiver |
| msgData | input | DATA_W | Payload of the arriving message |
| releaseCmd | input | 1 | Discard the head message |
| clearOvrCmd | input | 1 | Reset the overrun flag |
| headData | output | DATA_W | Oldest held message |
| rxAvail | output | 1 | At least one message is held |
| ovrStatus | output | 1 | Sticky overrun flag |
| rxIrq | output | 1 | Receive interrupt level |
| ovrIrq | output | 1 | Overrun interrupt pulse |

## Verification
The bench builds the store with DATA_W=16 and HOLDOFF=3. A hold-off of three cycles is longer than the fixed two-cycle window covered by the assertions, so the bench alone checks where the interrupt comes back after a release. A 16-bit payload keeps distinct values easy to tell apart in the ordering and overrun checks.

// File: rtl/rx_pair_pkg.sv
package rx_pair_pkg;
  typedef struct packed {
    logic loadHead;
    logic loadTail;
    logic shiftUp;
  } storeCtl_t;
endpackage

// File: rtl/rx_pair_data.sv
module rx_pair_data
  import rx_pair_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  storeCtl_t         ctl,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] headWord
);
  logic [DATA_W-1:0] slotHead;
  logic [DATA_W-1:0] slotTail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slotHead <= '0;
      slotTail <= '0;
    end else begin
      if (ctl.shiftUp)       slotHead <= slotTail;
      else if (ctl.loadHead) slotHead <= inData;
      if (ctl.loadTail)      slotTail <= inData;
    end
  end

  assign headWord = slotHead;
endmodule

// File: rtl/rx_pair_ctrl.sv
module rx_pair_ctrl
  import rx_pair_pkg::*;
#(
  parameter int HOLDOFF = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      msgValid,
  input  logic      releaseCmd,
  input  logic      clearOvrCmd,
  output storeCtl_t ctl,
  output logic      rxAvail,
  output logic      ovrStatus,
  output logic      rxIrq,
  output logic      ovrIrq
);
  localparam int HW = $clog2(HOLDOFF + 1);
  localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLDOFF);

  logic [1:0]    fill;
  logic [1:0]    fillNext;
  logic [HW-1:0] holdCnt;
  logic          relEff;
  logic          isFull;
  logic          accept;
  logic          ovrEvent;

  assign isFull   = (fill == 2'd2);
  assign relEff   = releaseCmd && (fill != 2'd0);
  assign accept   = msgValid && !(isFull && !relEff);
  assign ovrEvent = msgValid && isFull && !relEff;

  always_comb begin
    ctl.loadHead = msgValid && ((fill == 2'd0) || (fill == 2'd1 && relEff));
    ctl.loadTail = msgValid && ((fill == 2'd1 && !relEff) || (isFull && relEff));
    ctl.shiftUp  = relEff && isFull;
    fillNext = fill;
    if (accept && !relEff)      fillNext = fill + 2'd1;
    else if (!accept && relEff) fillNext = fill - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill      <= 2'd0;
      holdCnt   <= '0;
      rxIrq     <= 1'b0;
      ovrStatus <= 1'b0;
      ovrIrq    <= 1'b0;
    end else begin
      fill <= fillNext;
      if (relEff) begin
        holdCnt <= HOLD_LOAD;
        rxIrq   <= 1'b0;
      end else if (holdCnt != '0) begin
        holdCnt <= holdCnt - 1'b1;
        rxIrq   <= 1'b0;
      end else begin
        rxIrq <= (fillNext != 2'd0);
      end
      if (ovrEvent)         ovrStatus <= 1'b1;
      else if (clearOvrCmd) ovrStatus <= 1'b0;
      ovrIrq <= ovrEvent && !ovrStatus;
    end
  end

  assign rxAvail = (fill != 2'd0);
endmodule

// File: rtl/rx_pair_store.sv
module rx_pair_store
  import rx_pair_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int HOLDOFF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msgValid,
  input  logic [DATA_W-1:0] msgData,
  input  logic              releaseCmd,
  input  logic              clearOvrCmd,
  output logic [DATA_W-1:0] headData,
  output logic              rxAvail,
  output logic              ovrStatus,
  output logic              rxIrq,
  output logic              ovrIrq
);
  storeCtl_t ctl;

  rx_pair_ctrl #(.HOLDOFF(HOLDOFF)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .msgValid(msgValid), .releaseCmd(releaseCmd),
    .clearOvrCmd(clearOvrCmd), .ctl(ctl), .rxAvail(rxAvail),
    .ovrStatus(ovrStatus), .rxIrq(rxIrq), .ovrIrq(ovrIrq)
  );

  rx_pair_data #(.DATA_W(DATA_W)) data_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .inData(msgData), .headWord(headData)
  );
endmodule

// File: rtl/rx_pair_store_chk.sv
module rx_pair_store_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msgValid,
  input logic [DATA_W-1:0] msgData,
  input logic              releaseCmd,
  input logic              clearOvrCmd,
  input logic [DATA_W-1:0] headData,
  input logic              rxAvail,
  input logic              ovrStatus,
  input logic              rxIrq,
  input logic              ovrIrq
);
  assert_irq_needs_msg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rxIrq |-> rxAvail);

  assert_irq_low_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (releaseCmd && rxAvail) |=> !rxIrq);

  assert_irq_low_two_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(releaseCmd && rxAvail, 2) |-> !rxIrq);

  assert_first_msg_at_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (msgValid && !rxAvail) |=> (rxAvail && headData == $past(msgData)));

  assert_ovr_pulse_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovrIrq |-> ovrStatus);

  assert_ovr_flag_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!msgValid && !clearOvrCmd) |=> (ovrStatus == $past(ovrStatus)));

  assert_no_pulse_when_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovrStatus |=> !ovrIrq);

  assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clearOvrCmd && !msgValid) |=> !ovrStatus);
endmodule

bind rx_pair_store rx_pair_store_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .msgValid(msgValid), .msgData(msgData),
  .releaseCmd(releaseCmd), .clearOvrCmd(clearOvrCmd), .headData(headData),
  .rxAvail(rxAvail), .ovrStatus(ovrStatus), .rxIrq(rxIrq), .ovrIrq(ovrIrq)
);

// File: tb/rx_pair_store_tb.sv
module rx_pair_store_tb_top;
  localparam int DW = 16;
  localparam int HO = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          msgValid = 1'b0;
  logic [DW-1:0] msgData = '0;
  logic          releaseCmd = 1'b0;
  logic          clearOvrCmd = 1'b0;
  logic [DW-1:0] headData;
  logic          rxAvail, ovrStatus, rxIrq, ovrIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_pair_store #(.DATA_W(DW), .HOLDOFF(HO)) dut_i (
    .clk(clk), .rst_n(rst_n), .msgValid(msgValid), .msgData(msgData),
    .releaseCmd(releaseCmd), .clearOvrCmd(clearOvrCmd), .headData(headData),
    .rxAvail(rxAvail), .ovrStatus(ovrStatus), .rxIrq(rxIrq), .ovrIrq(ovrIrq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle of inputs, return at the negedge after the sampling edge
  task automatic step(input logic v, input logic [DW-1:0] d, input logic rel, input logic clr);
    msgValid = v; msgData = d; releaseCmd = rel; clearOvrCmd = clr;
    @(negedge clk);
    msgValid = 1'b0; releaseCmd = 1'b0; clearOvrCmd = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) step(1'b0, '0, rxAvail, 1'b1);
    for (int i = 0; i < HO + 1; i++) step(1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic test_reset();
    chk("R1 rxAvail", rxAvail, 0);
    chk("R1 ovrStatus", ovrStatus, 0);
    chk("R1 rxIrq", rxIrq, 0);
    chk("R1 ovrIrq", ovrIrq, 0);
  endtask

  task automatic test_single();
    step(1'b1, 16'hA11A, 1'b0, 1'b0);
    chk("R2 rxAvail", rxAvail, 1);
    chk("R2 head", headData, 16'hA11A);
    chk("R2 rxIrq", rxIrq, 1);
    step(1'b0, '0, 1'b1, 1'b0);
    chk("R4 rxAvail", rxAvail, 0);
    chk("R4 rxIrq", rxIrq, 0);
    drain();
  endtask

  task automatic test_order_holdoff();
    step(1'b1, 16'h1111, 1'b0, 1'b0);
    step(1'b1, 16'h2222, 1'b0, 1'b0);
    chk("R3 head first", headData, 16'h1111);
    step(1'b0, '0, 1'b1, 1'b0);
    chk("R3 head second", headData, 16'h2222);
    chk("R3 rxAvail", rxAvail, 1);
    chk("R5 irq low at k", rxIrq, 0);
    for (int i = 1; i <= HO; i++) begin
      step(1'b0, '0, 1'b0, 1'b0);
      chk("R5 irq low in hold-off", rxIrq, 0);
    end
    step(1'b0, '0, 1'b0, 1'b0);
    chk("R5 irq back", rxIrq, 1);
    drain();
  endtask

  task automatic test_overrun();
    step(1'b1, 16'h0AAA, 1'b0, 1'b0);
    step(1'b1, 16'h0BBB, 1'b0, 1'b0);
    step(1'b1, 16'h0CCC, 1'b0, 1'b0);
    chk("R6 ovrStatus", ovrStatus, 1);
    chk("R7 ovrIrq pulse", ovrIrq, 1);
    step(1'b0, '0, 1'b0, 1'b0);
    chk("R7 pulse one cycle", ovrIrq, 0);
    step(1'b1, 16'h0DDD, 1'b0, 1'b0);
    chk("R7 no second pulse", ovrIrq, 0);
    chk("R6 head kept", headData, 16'h0AAA);
    step(1'b0, '0, 1'b1, 1'b0);
    chk("R6 tail kept", headData, 16'h0BBB);
    step(1'b0, '0, 1'b0, 1'b1);
    chk("R8 cleared", ovrStatus, 0);
    drain();
  endtask

  task automatic test_clear_race();
    step(1'b1, 16'h0101, 1'b0, 1'b0);
    step(1'b1, 16'h0202, 1'b0, 1'b0);
    step(1'b1, 16'h0303, 1'b0, 1'b0);
    step(1'b1, 16'h0404, 1'b0, 1'b1);
    chk("R8 set wins over clear", ovrStatus, 1);
    chk("R7 no pulse while set", ovrIrq, 0);
    drain();
  endtask

  task automatic test_release_empty();
    step(1'b0, '0, 1'b1, 1'b0);
    chk("R9 rxAvail", rxAvail, 0);
    chk("R9 rxIrq", rxIrq, 0);
    chk("R9 ovrStatus", ovrStatus, 0);
    step(1'b1, 16'h7777, 1'b0, 1'b0);
    chk("R9 next msg normal", rxIrq, 1);
    chk("R9 head", headData, 16'h7777);
    drain();
  endtask

  task automatic test_swap_full();
    step(1'b1, 16'h5001, 1'b0, 1'b0);
    step(1'b1, 16'h5002, 1'b0, 1'b0);
    step(1'b1, 16'h5003, 1'b1, 1'b0);
    chk("R10 no overrun", ovrStatus, 0);
    chk("R10 head", headData, 16'h5002);
    step(1'b0, '0, 1'b1, 1'b0);
    chk("R10 accepted msg", headData, 16'h5003);
    chk("R10 rxAvail", rxAvail, 1);
    step(1'b0, '0, 1'b1, 1'b0);
    chk("R4 empty after last", rxAvail, 0);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_single();
    test_order_holdoff();
    test_overrun();
    test_clear_race();
    test_release_empty();
    test_swap_full();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule